// File: doc/BRIEF.md
# Disk Sector Frame Formatter

This block builds the complete byte sequence of one low-level-formatted sector for a magnetic disk track. A single start pulse captures the four identity bytes of the sector: track, head, sector number and a status byte that marks a sector as bad or remapped. The block then emits the whole frame one byte per cycle, in order: leading sync, address mark, fill gap, a second sync, the ID mark, the four ID bytes, a CRC over them, a short gap, the data mark, the 512 user bytes and three trailing gaps.

User data enters through a ready/valid byte port. Each data byte passes straight through to the output in the cycle it is accepted. Every output byte carries a field tag and a flag that marks the first byte of its field, so the write channel that follows can tell the fields apart. The output never waits on a downstream ready. Its only stall comes from missing input data: when no user byte is available during the data field, no output byte is produced.

Top module: `sector_formatter`

## Requirements
- R1: After reset, and at any time no frame is running, `busy`, `dout_valid`, `din_ready` and `done` are low.
- R2: A `start` pulse while idle captures `trk_in`, `head_in`, `sect_in` and `stat_in`. From the next cycle the block is busy, and its first output byte is 00h with tag 0 and `dout_first` high.
- R3: The frame opens with these fields and tags: 11 bytes of 00h (tag 0), then A1h FCh (tag 1), then 12 bytes of FFh (tag 2), then 10 bytes of 00h (tag 3), then 5Eh A1h (tag 4).
- R4: The ID field (tag 5) is the captured track, head, sector and status bytes, in that order.
- R5: Two check bytes (tag 6) follow the ID, high byte first. They are a CRC-16 over the four ID bytes: polynomial 1021h, preset FFFFh, bits taken most significant first, no reflection and no final inversion.
- R6: The check bytes are followed by 5 bytes of 00h (tag 7) and then 5Eh A1h (tag 8).
- R7: The data field (tag 9) is exactly 512 bytes. Each byte equals the `din` accepted in that cycle, in arrival order. `din_ready` is high only while the data field is being sent.
- R8: During the data field, a cycle with `din_valid` low produces no output byte and does not advance the frame.
- R9: After the data come 3 bytes of 00h (tag 10), then 17 bytes of FFh (tag 11), then 93 bytes of 00h (tag 12).
- R10: A frame has 675 output bytes. `done` is high for exactly one cycle, the cycle after the last byte, and `busy` is low in that cycle.
- R11: A `start` pulse while a frame is running has no effect: the frame continues with the same byte sequence and length.
- R12: `dout_first` is high on the first byte of each field and low on every other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins one frame when idle |
| trk_in | input | 8 | Track number, captured at start |
| head_in | input | 8 | Head number, captured at start |
| sect_in | input | 8 | Sector number, captured at start |
| stat_in | input | 8 | Sector status byte, captured at start |
| din | input | 8 | User data byte |
| din_valid | input | 1 | `din` holds a byte |
| din_ready | output | 1 | Data field in progress, byte accepted when valid |
| dout | output | 8 | Frame byte |
| dout_valid | output | 1 | `dout` holds a frame byte this cycle |
| dout_first | output | 1 | First byte of a field |
| dout_kind | output | 4 | Field tag, 0 to 12 |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the final byte |

## Verification
The assertions check the following on every cycle:
- The output is silent when idle.
- In the data field, an output byte is emitted only on a completed input handshake.
- A data stall suppresses output.
- Field tags only step forward by one, and the first-byte flag is raised at each step.
- A start pulse during a frame never ends it early.
- `done` is a single pulse that arrives after exactly the full frame length.

Only the bench's scenarios can show the byte values: the fixed marks and fills, the captured ID, the CRC result and the order of the data. The bench also checks that these values hold under several data-stall patterns and with stray start pulses during the frame.

// File: rtl/sector_formatter.sv
module sector_formatter #(
  parameter int LEAD_SYNC = 11,
  parameter int GAP_FF    = 12,
  parameter int SYNC2_LEN = 10,
  parameter int POST_ID   = 5,
  parameter int DATA_LEN  = 512,
  parameter int TAIL_ZERO = 3,
  parameter int TAIL_FF   = 17,
  parameter int CLOSE_LEN = 93
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] trk_in,
  input  logic [7:0] head_in,
  input  logic [7:0] sect_in,
  input  logic [7:0] stat_in,
  input  logic [7:0] din,
  input  logic       din_valid,
  output logic       din_ready,
  output logic [7:0] dout,
  output logic       dout_valid,
  output logic       dout_first,
  output logic [3:0] dout_kind,
  output logic       busy,
  output logic       done
);
  localparam int CW = $clog2(DATA_LEN + CLOSE_LEN + 64);
  localparam logic [3:0] K_SYNC = 4'd0, K_AM = 4'd1, K_GAPF = 4'd2, K_SYNC2 = 4'd3,
                         K_IDAM = 4'd4, K_ID = 4'd5, K_IDCRC = 4'd6, K_GAP2 = 4'd7,
                         K_DAM = 4'd8, K_DATA = 4'd9, K_TZ = 4'd10, K_TF = 4'd11,
                         K_CLOSE = 4'd12;

  logic [3:0]    kind_q;
  logic [CW-1:0] cnt_q, flen;
  logic          busy_q, done_q;
  logic [7:0]    trk_q, hd_q, sec_q, st_q;
  logic [15:0]   crc_w;

  function automatic logic [15:0] id_crc(input logic [31:0] m);
    logic [15:0] c;
    logic        fb;
    c = 16'hFFFF;
    for (int i = 31; i >= 0; i--) begin
      fb = c[15] ^ m[i];
      c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  assign crc_w = id_crc({trk_q, hd_q, sec_q, st_q});

  always_comb begin
    case (kind_q)
      K_SYNC:  flen = CW'(LEAD_SYNC);
      K_AM, K_IDAM, K_IDCRC, K_DAM: flen = CW'(2);
      K_GAPF:  flen = CW'(GAP_FF);
      K_SYNC2: flen = CW'(SYNC2_LEN);
      K_ID:    flen = CW'(4);
      K_GAP2:  flen = CW'(POST_ID);
      K_DATA:  flen = CW'(DATA_LEN);
      K_TZ:    flen = CW'(TAIL_ZERO);
      K_TF:    flen = CW'(TAIL_FF);
      default: flen = CW'(CLOSE_LEN);
    endcase
  end

  always_comb begin
    case (kind_q)
      K_AM:           dout = cnt_q[0] ? 8'hFC : 8'hA1;
      K_GAPF, K_TF:   dout = 8'hFF;
      K_IDAM, K_DAM:  dout = cnt_q[0] ? 8'hA1 : 8'h5E;
      K_ID: begin
        case (cnt_q[1:0])
          2'd0: dout = trk_q;
          2'd1: dout = hd_q;
          2'd2: dout = sec_q;
          default: dout = st_q;
        endcase
      end
      K_IDCRC:        dout = cnt_q[0] ? crc_w[7:0] : crc_w[15:8];
      K_DATA:         dout = din;
      default:        dout = 8'h00;
    endcase
  end

  assign din_ready  = busy_q && (kind_q == K_DATA);
  assign dout_valid = busy_q && ((kind_q != K_DATA) || din_valid);
  assign dout_first = busy_q && (cnt_q == '0);
  assign dout_kind  = kind_q;
  assign busy       = busy_q;
  assign done       = done_q;

  wire last_byte = (cnt_q == flen - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      kind_q <= K_SYNC;
      cnt_q  <= '0;
      trk_q  <= 8'h00;
      hd_q   <= 8'h00;
      sec_q  <= 8'h00;
      st_q   <= 8'h00;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          kind_q <= K_SYNC;
          cnt_q  <= '0;
          trk_q  <= trk_in;
          hd_q   <= head_in;
          sec_q  <= sect_in;
          st_q   <= stat_in;
        end
      end else if (dout_valid) begin
        if (last_byte) begin
          cnt_q <= '0;
          if (kind_q == K_CLOSE) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            kind_q <= kind_q + 4'd1;
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sector_formatter_chk.sv
module sector_formatter_chk #(
  parameter int TOTAL = 675
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       din_valid,
  input logic       din_ready,
  input logic       dout_valid,
  input logic       dout_first,
  input logic [3:0] dout_kind,
  input logic       busy,
  input logic       done
);
  logic [11:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen <= '0;
    else if (done)       seen <= '0;
    else if (dout_valid) seen <= seen + 12'd1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dout_valid && !din_ready && !dout_first)); // R1
  AST_DATA_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && dout_kind == 4'd9) |-> (din_valid && din_ready)); // R7
  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (din_ready && !din_valid) |=> $stable(dout_kind)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (seen == 12'(TOTAL) && !busy)); // R10
  AST_KIND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && dout_kind != $past(dout_kind)) |-> dout_kind == $past(dout_kind) + 4'd1); // R11
  AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(dout_valid && dout_kind == 4'd12)) |=> busy); // R11
  AST_FIRST_AT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && dout_kind != $past(dout_kind)) |-> dout_first); // R12
endmodule

bind sector_formatter sector_formatter_chk #(
  .TOTAL(LEAD_SYNC + 2 + GAP_FF + SYNC2_LEN + 2 + 4 + 2 + POST_ID + 2 + DATA_LEN + TAIL_ZERO + TAIL_FF + CLOSE_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .din_valid(din_valid), .din_ready(din_ready),
  .dout_valid(dout_valid), .dout_first(dout_first), .dout_kind(dout_kind), .busy(busy), .done(done)
);

// File: tb/sim_sector_formatter.sv
module sim_sector_formatter;
  localparam int CLK_PERIOD = 10;
  localparam int TOTAL = 675;
  localparam int NF = 13;
  localparam int WATCHDOG = 150000;
  // {kind, mode, len, b0, b1}; mode 0 fill, 1 pair, 2 id, 3 crc, 4 data
  localparam logic [32:0] FIELDS [NF] = '{
    {4'd0,  3'd0, 10'd11,  8'h00, 8'h00},
    {4'd1,  3'd1, 10'd2,   8'hA1, 8'hFC},
    {4'd2,  3'd0, 10'd12,  8'hFF, 8'h00},
    {4'd3,  3'd0, 10'd10,  8'h00, 8'h00},
    {4'd4,  3'd1, 10'd2,   8'h5E, 8'hA1},
    {4'd5,  3'd2, 10'd4,   8'h00, 8'h00},
    {4'd6,  3'd3, 10'd2,   8'h00, 8'h00},
    {4'd7,  3'd0, 10'd5,   8'h00, 8'h00},
    {4'd8,  3'd1, 10'd2,   8'h5E, 8'hA1},
    {4'd9,  3'd4, 10'd512, 8'h00, 8'h00},
    {4'd10, 3'd0, 10'd3,   8'h00, 8'h00},
    {4'd11, 3'd0, 10'd17,  8'hFF, 8'h00},
    {4'd12, 3'd0, 10'd93,  8'h00, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, din_valid = 1'b0;
  logic [7:0] trk_in = 8'h00, head_in = 8'h00, sect_in = 8'h00, stat_in = 8'h00, din = 8'h00;
  logic din_ready, dout_valid, dout_first, busy, done;
  logic [7:0] dout;
  logic [3:0] dout_kind;
  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] exp_b [TOTAL];
  logic [3:0] exp_k [TOTAL];
  logic       exp_f [TOTAL];

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_formatter u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .trk_in(trk_in), .head_in(head_in),
    .sect_in(sect_in), .stat_in(stat_in), .din(din), .din_valid(din_valid),
    .din_ready(din_ready), .dout(dout), .dout_valid(dout_valid), .dout_first(dout_first),
    .dout_kind(dout_kind), .busy(busy), .done(done)
  );

  function automatic logic [15:0] ref_crc(input logic [7:0] b [4]);
    logic [15:0] r = 16'hFFFF;
    for (int k = 0; k < 4; k++) begin
      r = r ^ {b[k], 8'h00};
      for (int j = 0; j < 8; j++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] dbyte(input int i, input logic [7:0] seed);
    return 8'(i * 7 + seed + (i >> 8));
  endfunction

  function automatic string req_of(input logic [3:0] k);
    case (k)
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7, 4'd8: return "R6";
      4'd9: return "R7";
      4'd10, 4'd11, 4'd12: return "R9";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic build(input logic [7:0] t, h, s, st, seed);
    logic [7:0] idb [4];
    logic [15:0] c;
    int p = 0;
    idb = '{t, h, s, st};
    c = ref_crc(idb);
    for (int f = 0; f < NF; f++) begin
      for (int n = 0; n < int'(FIELDS[f][25:16]); n++) begin
        exp_k[p] = FIELDS[f][32:29];
        exp_f[p] = (n == 0);
        case (FIELDS[f][28:26])
          3'd0: exp_b[p] = FIELDS[f][15:8];
          3'd1: exp_b[p] = (n == 0) ? FIELDS[f][15:8] : FIELDS[f][7:0];
          3'd2: exp_b[p] = idb[n];
          3'd3: exp_b[p] = (n == 0) ? c[15:8] : c[7:0];
          default: exp_b[p] = dbyte(n, seed);
        endcase
        p++;
      end
    end
  endtask

  function automatic bit stall_on(input int mode, input int g);
    case (mode)
      1: return (g % 2) == 1;
      2: return (g % 7) < 3;
      3: return (g % 50) < 40;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_frame(input logic [7:0] t, h, s, st, seed, input int mode, input bit poke);
    int pos = 0, didx = 0, stall_bad = 0, ready_bad = 0, g = 0;
    build(t, h, s, st, seed);
    @(negedge clk);
    trk_in = t; head_in = h; sect_in = s; stat_in = st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    trk_in = ~t; head_in = ~h; sect_in = ~s; stat_in = ~st;
    #1;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    while (pos < TOTAL && g < 20000) begin
      din = dbyte(didx, seed);
      din_valid = !stall_on(mode, g);
      start = poke && (pos == 100 || pos == 600);
      #1;
      if (din_ready && exp_k[pos] != 4'd9) ready_bad++;
      if (din_ready && !din_valid && dout_valid) stall_bad++;
      if (dout_valid) begin
        check(dout == exp_b[pos] && dout_kind == exp_k[pos], req_of(exp_k[pos]),
              $sformatf("byte %0d {kind,value}", pos), {dout_kind, dout}, {exp_k[pos], exp_b[pos]});
        check(dout_first == exp_f[pos], "R12", $sformatf("first flag byte %0d", pos), dout_first, exp_f[pos]);
        if (din_ready && din_valid) didx++;
        pos++;
      end
      @(negedge clk);
      g++;
    end
    start = 1'b0;
    din_valid = 1'b0;
    #1;
    check(pos == TOTAL, poke ? "R11" : "R10", "bytes emitted", pos, TOTAL);
    check(done == 1'b1 && busy == 1'b0, "R10", "done after last byte", {done, busy}, 2'b10);
    check(dout_valid == 1'b0, "R1", "silent after frame", dout_valid, 0);
    check(didx == 512, "R7", "data handshakes", didx, 512);
    check(ready_bad == 0, "R7", "ready outside data field", ready_bad, 0);
    check(stall_bad == 0, "R8", "output during stall", stall_bad, 0);
    @(negedge clk);
    #1;
    check(done == 1'b0, "R10", "done one cycle", done, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check({busy, dout_valid, din_ready, done} == 4'b0, "R1", "reset state",
          {busy, dout_valid, din_ready, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check({busy, dout_valid, din_ready, done} == 4'b0, "R1", "idle without start",
          {busy, dout_valid, din_ready, done}, 0);
    run_frame(8'd12, 8'd3, 8'd7, 8'h00, 8'h11, 0, 1'b0);
    run_frame(8'hFE, 8'd1, 8'h3F, 8'h80, 8'h5A, 1, 1'b1);
    run_frame(8'h00, 8'h00, 8'h00, 8'h01, 8'hC3, 2, 1'b1);
    run_frame(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 3, 1'b0);
    // reset in the middle of a frame returns to idle
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check({busy, dout_valid, din_ready, done} == 4'b0, "R1", "reset mid-frame",
          {busy, dout_valid, din_ready, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_frame(8'h42, 8'd2, 8'd9, 8'h40, 8'h77, 0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule